// File: doc/BRIEF.md
# Clock Output Enable and Power-Down Controller

This block produces the control signals for the two clock outputs of a clock generator: the spread main clock and a buffered copy of the reference. It takes an active-low power-down pin, an active-low reference-output enable, a test pin and a PLL lock indication. From them it derives, for each output, a gate enable and an output-enable (low means three-state), plus a reduced-power flag for the rest of the chip. The clock buffers and the analog power-down themselves lie outside this block.

All pins are synchronised on the reference clock and decoded. The resulting controls take effect a fixed number of reference edges after a pin changes. A gate enable only moves while the clock it gates is low. After power-down ends, the main clock gate stays closed until lock has been seen. A timeout counter raises a failure flag if lock does not come within the allowed window.

Top module: `clk_out_ctrl`

## Requirements
- R1: With `pd_ni` low, both gate enables are 0 and `low_power_o` is 1; with `pd_ni` high, `low_power_o` is 0.
- R2: `ref_en_o` is 1 exactly when `pd_ni` is high and `ref_en_ni` is low.
- R3: `main_oe_o` is 0 (main output three-stated) exactly when `test_i` and `ref_en_ni` are both high, whatever the state of `pd_ni`.
- R4: `ref_oe_o` is 0 (reference output three-stated) exactly when `pd_ni` and `ref_en_ni` are both high.
- R5: With the gated-clock level inputs low, every control output takes its new value on the 4th rising `ref_clk_i` edge after a pin change, counting the first edge that samples the new level as edge 1. Through edge 3 it keeps its old value.
- R6: `main_en_o` is 1 only while `pd_ni` is high and `pll_lock_i` has been seen high since `pd_ni` last went high. A later drop of lock does not close the gate; power-down does.
- R7: `main_en_o` changes only at edges where `main_lvl_i` is 0, and `ref_en_o` only at edges where `ref_lvl_i` is 0. Otherwise each holds its value.
- R8: With `TMO = REF_KHZ * LOCK_MS`, `lock_fail_o` rises on edge `TMO+2` after `pd_ni` rises while `pll_lock_i` stays low. It is low through edge `TMO+1`. It clears by edge 3 after lock is seen or `pd_ni` falls.
- R9: During reset the outputs are `main_en_o`=0, `main_oe_o`=1, `ref_en_o`=0, `ref_oe_o`=1, `low_power_o`=1 and `lock_fail_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk_i | input | 1 | Reference clock; all timing counts its rising edges |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pd_ni | input | 1 | Power-down request, active low, asynchronous |
| ref_en_ni | input | 1 | Reference output enable, active low; also qualifies three-state modes |
| test_i | input | 1 | Test pin; with `ref_en_ni` high it three-states the main output |
| pll_lock_i | input | 1 | PLL lock indication, asynchronous |
| main_lvl_i | input | 1 | Current level of the main clock, synchronous to `ref_clk_i` |
| ref_lvl_i | input | 1 | Current level of the reference clock copy, synchronous to `ref_clk_i` |
| main_en_o | output | 1 | Main clock gate enable |
| main_oe_o | output | 1 | Main clock driver enable (0 = three-state) |
| ref_en_o | output | 1 | Reference clock gate enable |
| ref_oe_o | output | 1 | Reference clock driver enable (0 = three-state) |
| low_power_o | output | 1 | Reduced-power mode flag |
| lock_fail_o | output | 1 | Lock not reported within the timeout window |

## Verification
A pin change reaches every control output on the fourth rising edge: two synchroniser edges, one pipeline edge, then the output register. The bench drives each pin pattern at a falling edge. It samples on the falling edge after the third rising edge, where the previous values are still expected, and again after the fourth, where the new ones are due. Under a high clock level the gate enables hold past edge 4 and move one edge after the level drops. The bench sweeps all sixteen pin patterns in two orders, and its lock model tracks whether lock has been seen since power-down ended. The failure flag is sampled after edge TMO+1, where it must still be low, and after edge TMO+2, where it must be high.

// File: rtl/clk_out_ctrl_pkg.sv
package clk_out_ctrl_pkg;
  typedef struct packed {
    logic main_on;
    logic ref_on;
    logic main_hiz;
    logic ref_hiz;
    logic low_pwr;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{main_on: 1'b0, ref_on: 1'b0, main_hiz: 1'b0,
                                 ref_hiz: 1'b0, low_pwr: 1'b1};
endpackage

// File: rtl/clk_out_sync.sv
module clk_out_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/clk_out_decode.sv
module clk_out_decode
  import clk_out_ctrl_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  pd_n_s_i,
  input  logic  ren_n_s_i,
  input  logic  test_s_i,
  input  logic  lock_s_i,
  output ctrl_t ctrl_o,
  output logic  waiting_o
);
  logic lock_ok_q, lock_ok_d;

  // lock is sticky from first sighting until the next power-down
  assign lock_ok_d = pd_n_s_i & (lock_ok_q | lock_s_i);
  assign waiting_o = pd_n_s_i & ~lock_ok_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lock_ok_q <= 1'b0;
    else         lock_ok_q <= lock_ok_d;
  end

  always_comb begin
    ctrl_o.main_on  = lock_ok_d;
    ctrl_o.ref_on   = pd_n_s_i & ~ren_n_s_i;
    ctrl_o.main_hiz = test_s_i & ren_n_s_i;
    ctrl_o.ref_hiz  = pd_n_s_i & ren_n_s_i;
    ctrl_o.low_pwr  = ~pd_n_s_i;
  end
endmodule

// File: rtl/clk_out_lock_tmr.sv
module clk_out_lock_tmr #(
  parameter int TMO = 71590
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic waiting_i,
  output logic fail_o
);
  localparam int CW = (TMO > 1) ? $clog2(TMO) : 1;
  localparam logic [CW-1:0] LAST = CW'(TMO - 1);

  logic [CW-1:0] cnt_q;
  logic          fail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      fail_q <= 1'b0;
    end else if (!waiting_i) begin
      cnt_q  <= '0;
      fail_q <= 1'b0;
    end else begin
      if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
      else               fail_q <= 1'b1;
    end
  end

  assign fail_o = fail_q;
endmodule

// File: rtl/clk_out_gate.sv
module clk_out_gate
  import clk_out_ctrl_pkg::*;
#(
  parameter int PIPE = 1
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  ctrl_t ctrl_i,
  input  logic  main_lvl_i,
  input  logic  ref_lvl_i,
  output logic  main_en_o,
  output logic  main_oe_o,
  output logic  ref_en_o,
  output logic  ref_oe_o,
  output logic  low_power_o
);
  ctrl_t dly;

  generate
    if (PIPE == 0) begin : g_nopipe
      assign dly = ctrl_i;
    end else begin : g_pipe
      ctrl_t pipe_q [PIPE];
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          for (int i = 0; i < PIPE; i++) pipe_q[i] <= CTRL_RST;
        end else begin
          pipe_q[0] <= ctrl_i;
          for (int i = 1; i < PIPE; i++) pipe_q[i] <= pipe_q[i-1];
        end
      end
      assign dly = pipe_q[PIPE-1];
    end
  endgenerate

  ctrl_t out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= CTRL_RST;
    end else begin
      out_q.main_hiz <= dly.main_hiz;
      out_q.ref_hiz  <= dly.ref_hiz;
      out_q.low_pwr  <= dly.low_pwr;
      // gate moves only in the low phase: no runt pulses
      if (!main_lvl_i) out_q.main_on <= dly.main_on;
      if (!ref_lvl_i)  out_q.ref_on  <= dly.ref_on;
    end
  end

  assign main_en_o   = out_q.main_on;
  assign ref_en_o    = out_q.ref_on;
  assign main_oe_o   = ~out_q.main_hiz;
  assign ref_oe_o    = ~out_q.ref_hiz;
  assign low_power_o = out_q.low_pwr;
endmodule

// File: rtl/clk_out_ctrl.sv
module clk_out_ctrl
  import clk_out_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int EN_DLY      = 4,
  parameter int REF_KHZ     = 14318,
  parameter int LOCK_MS     = 5
) (
  input  logic ref_clk_i,
  input  logic rst_ni,
  input  logic pd_ni,
  input  logic ref_en_ni,
  input  logic test_i,
  input  logic pll_lock_i,
  input  logic main_lvl_i,
  input  logic ref_lvl_i,
  output logic main_en_o,
  output logic main_oe_o,
  output logic ref_en_o,
  output logic ref_oe_o,
  output logic low_power_o,
  output logic lock_fail_o
);
  localparam int PIPE = EN_DLY - SYNC_STAGES - 1;
  localparam int TMO  = REF_KHZ * LOCK_MS;

  logic [3:0] pins_s;
  ctrl_t      ctrl;
  logic       waiting;

  clk_out_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (ref_clk_i),
    .rst_ni (rst_ni),
    .d_i    ({pd_ni, ref_en_ni, test_i, pll_lock_i}),
    .q_o    (pins_s)
  );

  clk_out_decode u_dec (
    .clk_i     (ref_clk_i),
    .rst_ni    (rst_ni),
    .pd_n_s_i  (pins_s[3]),
    .ren_n_s_i (pins_s[2]),
    .test_s_i  (pins_s[1]),
    .lock_s_i  (pins_s[0]),
    .ctrl_o    (ctrl),
    .waiting_o (waiting)
  );

  clk_out_lock_tmr #(.TMO(TMO)) u_tmr (
    .clk_i     (ref_clk_i),
    .rst_ni    (rst_ni),
    .waiting_i (waiting),
    .fail_o    (lock_fail_o)
  );

  clk_out_gate #(.PIPE(PIPE)) u_gate (
    .clk_i       (ref_clk_i),
    .rst_ni      (rst_ni),
    .ctrl_i      (ctrl),
    .main_lvl_i  (main_lvl_i),
    .ref_lvl_i   (ref_lvl_i),
    .main_en_o   (main_en_o),
    .main_oe_o   (main_oe_o),
    .ref_en_o    (ref_en_o),
    .ref_oe_o    (ref_oe_o),
    .low_power_o (low_power_o)
  );
endmodule

// File: rtl/clk_out_ctrl_chk.sv
module clk_out_ctrl_chk (
  input logic ref_clk_i,
  input logic rst_ni,
  input logic pll_lock_i,
  input logic main_lvl_i,
  input logic ref_lvl_i,
  input logic main_en_o,
  input logic main_oe_o,
  input logic ref_en_o,
  input logic ref_oe_o,
  input logic low_power_o,
  input logic lock_fail_o
);
  p_main_rise_powered_r1: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    $rose(main_en_o) |-> !low_power_o);

  p_ref_rise_driven_r2: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    $rose(ref_en_o) |-> (ref_oe_o && !low_power_o));

  p_ref_hiz_powered_r4: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    !ref_oe_o |-> !low_power_o);

  p_main_gate_low_r7: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    !$stable(main_en_o) |-> !$past(main_lvl_i));

  p_ref_gate_low_r7: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    !$stable(ref_en_o) |-> !$past(ref_lvl_i));

  p_fail_no_lock_r8: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    $rose(lock_fail_o) |-> !$past(pll_lock_i, 2));

  p_fail_powered_r8: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    lock_fail_o |-> !low_power_o);
endmodule

bind clk_out_ctrl clk_out_ctrl_chk u_chk (
  .ref_clk_i   (ref_clk_i),
  .rst_ni      (rst_ni),
  .pll_lock_i  (pll_lock_i),
  .main_lvl_i  (main_lvl_i),
  .ref_lvl_i   (ref_lvl_i),
  .main_en_o   (main_en_o),
  .main_oe_o   (main_oe_o),
  .ref_en_o    (ref_en_o),
  .ref_oe_o    (ref_oe_o),
  .low_power_o (low_power_o),
  .lock_fail_o (lock_fail_o)
);

// File: tb/clk_out_ctrl_tb.sv
module clk_out_ctrl_tb;
  localparam int REF_KHZ = 8;
  localparam int LOCK_MS = 5;
  localparam int TMO     = REF_KHZ * LOCK_MS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pd_n = 1'b0, ren_n = 1'b0, tst = 1'b0, lk = 1'b0;
  logic mlvl = 1'b0, rlvl = 1'b0;
  logic main_en, main_oe, ref_en, ref_oe, low_pwr, lock_fail;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic seen = 1'b0;
  logic [4:0] cur;

  always #4 clk = ~clk;

  clk_out_ctrl #(.REF_KHZ(REF_KHZ), .LOCK_MS(LOCK_MS)) u_dut (
    .ref_clk_i(clk), .rst_ni(rst_n), .pd_ni(pd_n), .ref_en_ni(ren_n),
    .test_i(tst), .pll_lock_i(lk), .main_lvl_i(mlvl), .ref_lvl_i(rlvl),
    .main_en_o(main_en), .main_oe_o(main_oe), .ref_en_o(ref_en),
    .ref_oe_o(ref_oe), .low_power_o(low_pwr), .lock_fail_o(lock_fail)
  );

  // {main_en, main_oe, ref_en, ref_oe, low_power}
  function automatic logic [4:0] expv(logic p, logic r, logic t, logic s);
    return {p & s, ~(t & r), p & ~r, ~(p & r), ~p};
  endfunction

  function automatic logic [4:0] outs();
    return {main_en, main_oe, ref_en, ref_oe, low_pwr};
  endfunction

  task automatic chk(string tag, logic [4:0] act, logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%b exp=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk1(string tag, logic act, logic exp);
    chk(tag, {4'b0, act}, {4'b0, exp});
  endtask

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // called at a negedge; drives pins and checks R5 timing plus decode
  task automatic step(logic p, logic r, logic t, logic l);
    logic [4:0] nxt;
    if (!p) seen = 1'b0;
    else if (l) seen = 1'b1;
    nxt = expv(p, r, t, seen);
    pd_n = p; ren_n = r; tst = t; lk = l;
    edges(3);
    chk("R5 old value held through edge 3", outs(), cur);
    edges(1);
    chk("R1 R2 R3 R4 R6 decode at edge 4", outs(), nxt);
    cur = nxt;
    edges(2);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 50000) begin
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    edges(3);
    chk("R9 reset outputs", outs(), 5'b01011);
    chk1("R9 reset lock_fail", lock_fail, 1'b0);
    rst_n = 1'b1;
    cur = expv(1'b0, 1'b0, 1'b0, 1'b0);
    edges(3);
    chk("R9 state after reset release", outs(), cur);

    // exhaustive sweep, binary order then gray order
    for (int i = 0; i < 16; i++) step(i[3], i[2], i[1], i[0]);
    for (int i = 15; i >= 0; i--) begin
      logic [3:0] g;
      g = 4'(i) ^ (4'(i) >> 1);
      step(g[3], g[2], g[1], g[0]);
    end

    // R6: lock drop does not close the main gate
    step(1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0, 1'b1);
    step(1'b1, 1'b0, 1'b0, 1'b0);
    chk1("R6 main stays on after lock drop", main_en, 1'b1);

    // R7: main gate held while its clock is high
    mlvl = 1'b1;
    pd_n = 1'b0;
    edges(4);
    chk1("R7 main_en held under high level", main_en, 1'b1);
    chk1("R1 low_power at edge 4", low_pwr, 1'b1);
    chk1("R1 ref gate off", ref_en, 1'b0);
    edges(3);
    chk1("R7 main_en still held", main_en, 1'b1);
    mlvl = 1'b0;
    edges(1);
    chk1("R7 main_en drops once level low", main_en, 1'b0);

    // R7: ref gate held while its clock is high
    rlvl = 1'b1;
    pd_n = 1'b1; lk = 1'b1;
    edges(4);
    chk1("R7 ref_en held under high level", ref_en, 1'b0);
    chk1("R6 main on with lock", main_en, 1'b1);
    rlvl = 1'b0;
    edges(1);
    chk1("R7 ref_en rises once level low", ref_en, 1'b1);
    seen = 1'b1;
    cur = expv(1'b1, 1'b0, 1'b0, 1'b1);
    edges(2);

    // R8: lock timeout, cleared by lock
    step(1'b0, 1'b0, 1'b0, 1'b0);
    pd_n = 1'b1;
    edges(TMO + 1);
    chk1("R8 lock_fail low at edge TMO+1", lock_fail, 1'b0);
    edges(1);
    chk1("R8 lock_fail high at edge TMO+2", lock_fail, 1'b1);
    chk1("R6 main off while unlocked", main_en, 1'b0);
    lk = 1'b1;
    edges(3);
    chk1("R8 lock_fail cleared by lock", lock_fail, 1'b0);
    edges(1);
    chk1("R6 main on after late lock", main_en, 1'b1);
    seen = 1'b1;
    cur = expv(1'b1, 1'b0, 1'b0, 1'b1);
    edges(2);

    // R8: lock timeout, cleared by power-down
    step(1'b0, 1'b0, 1'b0, 1'b0);
    pd_n = 1'b1;
    edges(TMO + 4);
    chk1("R8 lock_fail set again", lock_fail, 1'b1);
    pd_n = 1'b0;
    edges(3);
    chk1("R8 lock_fail cleared by power-down", lock_fail, 1'b0);
    edges(3);
    chk("R1 powered down after timeout", outs(), expv(1'b0, 1'b0, 1'b0, 1'b0));

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule